// File: doc/BRIEF.md
# Serial Pin Configuration Message Receiver

This block sits at one I/O pin and watches the direction control line that the processor drives to it. Ordinary software can move that line at most once every two clocks, so a high level lasting exactly one clock can only come from hardware. A framed message uses exactly that shape. It starts with the pattern low, high, low, one bit per clock. The pattern is followed by a 32-bit payload, most significant bit first, and a closing low bit. When the block sees the start pattern, it shifts in the payload and checks the closing bit. It then hands the word, with a one-cycle strobe, to a small mode register that puts the pin into a special mode or takes it out again.

The pin driver must keep seeing the line's ordinary meaning. To make that possible, the block passes the line to the driver three clocks late and removes every frame bit from that copy. During a frame, the driver keeps the level it had before the first start bit. Once a mode word is latched, later levels on the line do not change it. Only another valid message, or the dedicated clear word, changes the mode.

A matching transmitter sends 32-bit replies toward the processor on the pin's IN line, using the same framing. It takes a new word only when it is idle.

Top module: `pin_cfg_link`

## Requirements
- R1: Outside frames, `drv_dir` equals the value `ctl_line` had three clocks earlier. After reset, `drv_dir` is 0.
- R2: A frame is `ctl_line` = 0,1,0 on three consecutive clocks, then 32 payload bits (most significant first), then a closing 0. The payload appears on `cfg_word`, and `cfg_stb` is high for exactly one clock, namely the clock after the closing bit.
- R3: No start is recognised while a frame is being received. A frame whose first start bit directly follows the previous closing bit is still received.
- R4: While a frame passes, `drv_dir` keeps the value it had before the frame's first start bit. No frame bit ever reaches `drv_dir`.
- R5: If the closing bit is 1, the frame is discarded: there is no strobe, and `cfg_word`, `mode_on` and `mode_word` keep their values.
- R6: Level changes on `ctl_line` in which every high and every low lasts at least two clocks never produce a strobe.
- R7: A valid word different from CLEAR_WORD sets `mode_on` to 1 and `mode_word` to that word one clock after the strobe. Later line levels leave both unchanged.
- R8: A valid word equal to CLEAR_WORD (default 0) clears `mode_on` and leaves `mode_word` unchanged.
- R9: When `tx_load` is high while the transmitter is idle, `in_line` sends 0,1,0, then `tx_word` most significant bit first, then 0. It sends one bit per clock, starting the clock after the load. `in_line` is 0 when idle.
- R10: `tx_busy` is high for exactly 36 clocks after an accepted load. A load while busy is ignored and does not disturb the frame in flight.
- R11: During and right after reset, `cfg_stb`, `mode_on`, `tx_busy` and `in_line` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_line | input | 1 | Direction control line from the processor, carrying messages |
| drv_dir | output | 1 | Direction level seen by the pin driver, with frame bits removed |
| cfg_word | output | 32 | Last valid payload received |
| cfg_stb | output | 1 | One-clock strobe marking a new valid payload |
| mode_on | output | 1 | Pin is in a special mode |
| mode_word | output | 32 | Configuration word of the current mode |
| tx_word | input | 32 | Reply word to send |
| tx_load | input | 1 | Request to send `tx_word` |
| tx_busy | output | 1 | Reply frame in progress |
| in_line | output | 1 | Serial reply toward the processor |

## Verification
Suppose the receiver's bit counter or the hold counter drifts by one. The port-level effects would then be a shifted `cfg_word`, a strobe one clock early or late, or a single frame bit leaking onto `drv_dir`. Each of these shows within about 36 clocks of the frame start. A false start detector shows as a strobe nobody sent, during slow toggling or right after a frame with a bad closing bit. A wrong transmitter count shows as a misplaced bit on `in_line`, or as `tx_busy` not lasting exactly 36 clocks.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  localparam int unsigned START_LEN = 3;
  localparam logic [START_LEN-1:0] START_PAT = 3'b010;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_STOP = 2'd2
  } rx_state_e;
endpackage

// File: rtl/pcl_dir_filter.sv
module pcl_dir_filter
  import pcl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic drv_dir_o,
  output logic start_o
);
  localparam int unsigned HOLD_LEN = DATA_W + START_LEN;
  localparam int unsigned HW = $clog2(HOLD_LEN + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_LEN);

  logic          s1_q, s2_q, drv_q, drv_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          quiet, pat, load_en;

  always_comb begin
    quiet   = (hold_q == '0);
    pat     = ({s2_q, s1_q, line_i} == START_PAT);
    start_o = pat & quiet;
    load_en = quiet & ~start_o;
    drv_d   = load_en ? s2_q : drv_q;
    if (start_o)     hold_d = HOLD_INIT;
    else if (!quiet) hold_d = hold_q - 1'b1;
    else             hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      drv_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      drv_q  <= drv_d;
      hold_q <= hold_d;
    end
  end

  assign drv_dir_o = drv_q;

  AST_DRV_FROM_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_q) |-> ($past(quiet) && drv_q == $past(s2_q))); // R1
endmodule

// File: rtl/pcl_rx_deframer.sv
module pcl_rx_deframer
  import pcl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              start_i,
  output logic [DATA_W-1:0] word_o,
  output logic              stb_o,
  output logic              busy_o
);
  localparam int unsigned CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] shift_q, shift_d, word_q, word_d;
  logic              stb_q, stb_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    word_d  = word_q;
    stb_d   = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (start_i) begin
          state_d = RX_DATA;
          cnt_d   = '0;
        end
      end
      RX_DATA: begin
        shift_d = {shift_q[DATA_W-2:0], line_i};
        if (cnt_q == LAST_BIT) state_d = RX_STOP;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      RX_STOP: begin
        if (!line_i) begin
          stb_d  = 1'b1;
          word_d = shift_q;
        end
        state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      word_q  <= '0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      word_q  <= word_d;
      stb_q   <= stb_d;
    end
  end

  assign word_o = word_q;
  assign stb_o  = stb_q;
  assign busy_o = (state_q != RX_IDLE);

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R2
  AST_STB_AFTER_GOOD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> ($past(state_q) == RX_STOP && !$past(line_i))); // R5
endmodule

// File: rtl/pcl_mode_latch.sv
module pcl_mode_latch #(
  parameter int unsigned        DATA_W     = 32,
  parameter logic [DATA_W-1:0]  CLEAR_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              mode_on_o,
  output logic [DATA_W-1:0] mode_word_o
);
  logic              on_q, on_d;
  logic [DATA_W-1:0] mw_q, mw_d;

  always_comb begin
    on_d = on_q;
    mw_d = mw_q;
    if (stb_i) begin
      if (word_i == CLEAR_WORD) begin
        on_d = 1'b0;
      end else begin
        on_d = 1'b1;
        mw_d = word_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
      mw_q <= '0;
    end else begin
      on_q <= on_d;
      mw_q <= mw_d;
    end
  end

  assign mode_on_o   = on_q;
  assign mode_word_o = mw_q;

  AST_MODE_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(on_q) || !$stable(mw_q)) |-> $past(stb_i)); // R7
endmodule

// File: rtl/pcl_tx_framer.sv
module pcl_tx_framer
  import pcl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word_i,
  input  logic              load_i,
  output logic              busy_o,
  output logic              line_o
);
  localparam int unsigned FL = DATA_W + START_LEN + 1;
  localparam int unsigned CW = $clog2(FL + 1);
  localparam logic [CW-1:0] FL_INIT = CW'(FL);

  logic [FL-1:0] sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy, accept;

  always_comb begin
    busy   = (cnt_q != '0);
    accept = load_i & ~busy;
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    if (accept) begin
      sr_d  = {START_PAT, word_i, 1'b0};
      cnt_d = FL_INIT;
    end else if (busy) begin
      sr_d  = {sr_q[FL-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy;
  assign line_o = sr_q[FL-1];

  AST_TX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_o); // R9
  AST_TX_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy) |=> (busy && !line_o)); // R10
endmodule

// File: rtl/pin_cfg_link.sv
module pin_cfg_link #(
  parameter int unsigned       DATA_W     = 32,
  parameter logic [DATA_W-1:0] CLEAR_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_line,
  output logic              drv_dir,
  output logic [DATA_W-1:0] cfg_word,
  output logic              cfg_stb,
  output logic              mode_on,
  output logic [DATA_W-1:0] mode_word,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tx_load,
  output logic              tx_busy,
  output logic              in_line
);
  logic rst_m_q, rst_s_q;
  logic start, rx_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  pcl_dir_filter #(.DATA_W(DATA_W)) u_filter (
    .clk(clk), .rst_n(rst_s_q), .line_i(ctl_line),
    .drv_dir_o(drv_dir), .start_o(start)
  );

  pcl_rx_deframer #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_s_q), .line_i(ctl_line), .start_i(start),
    .word_o(cfg_word), .stb_o(cfg_stb), .busy_o(rx_busy)
  );

  pcl_mode_latch #(.DATA_W(DATA_W), .CLEAR_WORD(CLEAR_WORD)) u_mode (
    .clk(clk), .rst_n(rst_s_q), .stb_i(cfg_stb), .word_i(cfg_word),
    .mode_on_o(mode_on), .mode_word_o(mode_word)
  );

  pcl_tx_framer #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_s_q), .word_i(tx_word), .load_i(tx_load),
    .busy_o(tx_busy), .line_o(in_line)
  );

  AST_DIR_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_s_q)
    rx_busy |=> $stable(drv_dir)); // R4
  AST_NO_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_s_q)
    start |-> !rx_busy); // R3
endmodule

// File: tb/test_pin_cfg_link.sv
`timescale 1ns/1ps
module test_pin_cfg_link;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_line = 1'b0;
  logic        drv_dir, cfg_stb, mode_on, tx_busy, in_line;
  logic [31:0] cfg_word, mode_word;
  logic [31:0] tx_word = '0;
  logic        tx_load = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int n_stb = 0;
  bit done  = 1'b0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  pin_cfg_link i_pin_cfg_link (
    .clk(clk), .rst_n(rst_n), .ctl_line(ctl_line), .drv_dir(drv_dir),
    .cfg_word(cfg_word), .cfg_stb(cfg_stb), .mode_on(mode_on),
    .mode_word(mode_word), .tx_word(tx_word), .tx_load(tx_load),
    .tx_busy(tx_busy), .in_line(in_line)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match the oldest expected word (R2)
  always @(negedge clk) begin
    if (rst_n && cfg_stb) begin
      n_stb++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R5 unexpected strobe", {32'h0, cfg_word}, 64'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(cfg_word == e, "R2 received word", {32'h0, cfg_word}, {32'h0, e});
      end
    end
  end

  // drives 0,1,0, payload MSB first, closing bit; returns at the closing-bit negedge
  task automatic send_frame(input logic [31:0] w, input bit close_bit);
    logic [35:0] f;
    f = {3'b010, w, close_bit};
    if (close_bit == 1'b0) exp_q.push_back(w);
    for (int i = 35; i >= 0; i--) begin
      @(negedge clk);
      ctl_line = f[i];
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_frame(input logic [31:0] w, input bit poke);
    logic [35:0] f;
    int bad;
    f = {3'b010, w, 1'b0};
    bad = 0;
    @(negedge clk);
    tx_word = w;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    for (int i = 35; i >= 0; i--) begin
      if (in_line !== f[i] || tx_busy !== 1'b1) bad++;
      if (poke && i == 25) begin
        tx_word = ~w;
        tx_load = 1'b1;
      end else begin
        tx_load = 1'b0;
      end
      @(negedge clk);
    end
    tx_load = 1'b0;
    check(bad == 0, "R9 reply frame bits", 64'(bad), 64'h0);
    check(tx_busy == 1'b0 && in_line == 1'b0, "R10 busy ends after 36 clocks",
          {62'h0, tx_busy, in_line}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s0;
    idle(3);
    check(drv_dir == 0 && cfg_stb == 0 && mode_on == 0 && tx_busy == 0 && in_line == 0,
          "R11 in reset", {59'h0, drv_dir, cfg_stb, mode_on, tx_busy, in_line}, 64'h0);
    rst_n = 1'b1;
    idle(6);
    check(cfg_stb == 0 && mode_on == 0 && tx_busy == 0 && in_line == 0 && drv_dir == 0,
          "R11 after reset", {59'h0, drv_dir, cfg_stb, mode_on, tx_busy, in_line}, 64'h0);

    // R1: three-clock latency
    @(negedge clk); ctl_line = 1'b1;
    idle(2);
    check(drv_dir == 1'b0, "R1 not yet after two clocks", {63'h0, drv_dir}, 64'h0);
    idle(1);
    check(drv_dir == 1'b1, "R1 after three clocks", {63'h0, drv_dir}, 64'h1);
    @(negedge clk); ctl_line = 1'b0;
    idle(3);
    check(drv_dir == 1'b0, "R1 falls after three clocks", {63'h0, drv_dir}, 64'h0);

    // R2, R7: valid frame
    idle(4);
    send_frame(32'hA5C3_1E0F, 1'b0);
    @(negedge clk); ctl_line = 1'b0;
    check(cfg_stb == 1'b1, "R2 strobe clock after closing bit", {63'h0, cfg_stb}, 64'h1);
    @(negedge clk);
    check(cfg_stb == 1'b0, "R2 strobe one clock wide", {63'h0, cfg_stb}, 64'h0);
    check(mode_on == 1'b1 && mode_word == 32'hA5C3_1E0F, "R7 mode latched",
          {31'h0, mode_on, mode_word}, {31'h0, 1'b1, 32'hA5C3_1E0F});

    // R4: line high before and after the frame, driver stays high
    @(negedge clk); ctl_line = 1'b1;
    idle(6);
    begin
      int leaks;
      leaks = 0;
      fork
        begin
          send_frame(32'h0F0F_F0F0, 1'b0);
          @(negedge clk); ctl_line = 1'b1;
        end
        begin
          repeat (45) begin
            @(negedge clk);
            if (drv_dir !== 1'b1) leaks++;
          end
        end
      join
      check(leaks == 0, "R4 frame bits kept from driver", 64'(leaks), 64'h0);
    end
    check(mode_word == 32'h0F0F_F0F0, "R7 second word", {32'h0, mode_word}, 64'h0F0F_F0F0);

    // R3: two frames back to back
    @(negedge clk); ctl_line = 1'b0;
    idle(4);
    send_frame(32'h1234_5678, 1'b0);
    send_frame(32'h8000_0001, 1'b0);
    @(negedge clk); ctl_line = 1'b0;
    idle(3);
    check(exp_q.size() == 0 && mode_word == 32'h8000_0001, "R3 back-to-back both received",
          {32'h0, mode_word}, 64'h8000_0001);

    // R5: bad closing bit discarded
    s0 = n_stb;
    send_frame(32'hDEAD_BEEF, 1'b1);
    @(negedge clk); ctl_line = 1'b0;
    idle(4);
    check(n_stb == s0 && cfg_word == 32'h8000_0001 && mode_word == 32'h8000_0001 && mode_on,
          "R5 bad frame ignored", {32'h0, mode_word}, 64'h8000_0001);

    // R6, R7: slow software toggling with two-clock pulses
    s0 = n_stb;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); ctl_line = ~ctl_line;
      @(negedge clk);
    end
    idle(5);
    check(n_stb == s0, "R6 slow toggles give no strobe", 64'(n_stb - s0), 64'h0);
    check(mode_on && mode_word == 32'h8000_0001, "R7 mode kept under line activity",
          {32'h0, mode_word}, 64'h8000_0001);
    check(drv_dir == ctl_line, "R1 driver follows slow line", {63'h0, drv_dir},
          {63'h0, ctl_line});

    // R8: clear word
    @(negedge clk); ctl_line = 1'b0;
    idle(3);
    send_frame(32'h0000_0000, 1'b0);
    @(negedge clk); ctl_line = 1'b0;
    idle(2);
    check(mode_on == 1'b0 && mode_word == 32'h8000_0001, "R8 clear word leaves mode",
          {31'h0, mode_on, mode_word}, {31'h0, 1'b0, 32'h8000_0001});

    // R9, R10: replies
    tx_frame(32'hC001_D00D, 1'b0);
    tx_frame(32'h5A5A_0FF0, 1'b1);
    idle(3);
    check(in_line == 1'b0 && tx_busy == 1'b0, "R10 load during busy ignored",
          {62'h0, tx_busy, in_line}, 64'h0);

    check(exp_q.size() == 0, "R2 all expected words seen", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule